// File: doc/BRIEF.md
# Linked-List Command Chain Walker

The walker follows a chain of command packets stored in memory and streams the payload of each packet, word by word, to a graphics command port. A packet begins with one header word. The upper byte of the header gives the number of payload words. The lower 24 bits give the address of the next packet. Software supplies a start address and pulses `start`. The walker then reads headers and payloads over a simple request/response memory port. It allows one read in flight at a time. Each payload word is held on the output until the command port accepts it.

The walk ends when an address has its stop flag (bit 23) set. That address is then published on `progress_addr`. While it walks, the walker adds a cost estimate for every packet: a fixed overhead of five plus the payload length. A chain that points back into itself would never reach a stop flag. A node counter guards against this: once `LOOP_LIMIT` packets have been walked and the next link is still live, the walk is cut short and `loop_hit` is raised.

Named states: IDLE (waiting for start), CHECK (test the stop flag of the current address), HDR_REQ / HDR_WAIT (issue and collect the header read), PAY_REQ / PAY_WAIT (issue and collect one payload read), PAY_SEND (offer the word to the command port), NEXT (adopt the link and apply the loop guard), DONE (result valid). Transitions:
- IDLE→CHECK and DONE→CHECK on start.
- CHECK→DONE when the stop flag is set, otherwise CHECK→HDR_REQ.
- HDR_REQ→HDR_WAIT and PAY_REQ→PAY_WAIT on request accept.
- HDR_WAIT→NEXT for an empty packet, otherwise HDR_WAIT→PAY_REQ.
- PAY_WAIT→PAY_SEND on response.
- PAY_SEND→PAY_REQ, or PAY_SEND→NEXT after the last word, on command accept.
- NEXT→DONE when the guard trips, otherwise NEXT→CHECK.

Top module: `chain_walker`

## Requirements
- R1: After reset, busy, done, loop_hit, cmd_valid and mem_req_valid are 0, and cycle_cost and progress_addr are 0.
- R2: Only the low 24 bits of start_addr are used. If bit 23 of that masked value is set, the walk ends with no memory read, cost 0, and progress_addr equal to the masked value.
- R3: A header word carries the payload length in bits 31:24 and the next packet address in bits 23:0.
- R4: A read address is bits 20:2 of the packet address with bits 1:0 cleared. Payload word k (from 1) of a packet is read from the header address plus 4*k, wrapping within the 21-bit space.
- R5: Payload words reach cmd_data in ascending address order, each exactly once. A packet of length 0 sends no word, and the walker fetches the next header directly.
- R6: The walk stops at the first address whose bit 23 is set. done then stays 1 and busy 0 until the next start, and progress_addr holds that address.
- R7: cycle_cost at the end of a walk equals the sum over all walked packets of 5 plus the payload length.
- R8: While cmd_valid is 1 and cmd_ready is 0, cmd_data stays unchanged, and no memory request is made while a word waits.
- R9: When LOOP_LIMIT packets have been walked and the next link has bit 23 clear, the walk stops with loop_hit 1 and progress_addr equal to that unwalked link. A new start clears loop_hit.
- R10: A memory request holds its address until mem_req_ready accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (taken in IDLE or DONE) |
| start_addr | input | 32 | First packet address; upper byte ignored |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 21 | Word-aligned byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| cmd_valid | output | 1 | Payload word valid |
| cmd_ready | input | 1 | Command port accepts the word |
| cmd_data | output | 32 | Payload word |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Walk finished; results valid |
| loop_hit | output | 1 | Walk cut short by the node guard |
| progress_addr | output | 24 | Address where the walk stopped |
| cycle_cost | output | 32 | Accumulated cost estimate |

## Verification
The chains exercised are:
- a start address already flagged as stopped, which separates the immediate exit from a one-packet walk;
- a mix of empty and non-empty packets, which shows that zero-length packets are skipped rather than sending a stray word;
- links with junk in bits 22:21 and 1:0, and a packet sitting at the top of the 21-bit space, which show masking and wrap of the address;
- a packet that links to itself, which trips the node guard at exactly its limit and checks both cost and progress;
- a chain run under random stalls on both the memory and the command side, which separates correct holding of a word from a word that is lost or repeated.

Each payload word carries a unique value, so a wrong read address shows up as a wrong word in the scoreboard.

// File: rtl/chain_walk_pkg.sv
package chain_walk_pkg;

    localparam int WORD_W   = 32;
    localparam int LEN_W    = 8;
    localparam int LINK_W   = 24;
    localparam int STOP_BIT = 23;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CHECK,
        ST_HDR_REQ,
        ST_HDR_WAIT,
        ST_PAY_REQ,
        ST_PAY_WAIT,
        ST_PAY_SEND,
        ST_NEXT,
        ST_DONE
    } walk_state_t;

endpackage

// File: rtl/chain_hdr_split.sv
module chain_hdr_split
    import chain_walk_pkg::*;
(
    input  logic [WORD_W-1:0] hdr_word,
    output logic [LEN_W-1:0]  hdr_len,
    output logic [LINK_W-1:0] hdr_link
);
    // length in the top byte, next link in the low bits
    assign hdr_len  = hdr_word[WORD_W-1 -: LEN_W];
    assign hdr_link = hdr_word[LINK_W-1:0];
endmodule

// File: rtl/chain_cost_acc.sv
module chain_cost_acc
    import chain_walk_pkg::*;
#(
    parameter int COST_W   = 32,
    parameter int OVERHEAD = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              add_en,
    input  logic [LEN_W-1:0]  add_len,
    output logic [COST_W-1:0] total
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            total <= '0;
        end else if (add_en) begin
            total <= total + COST_W'(OVERHEAD) + COST_W'(add_len);
        end
    end
endmodule

// File: rtl/chain_loop_guard.sv
module chain_loop_guard #(
    parameter int LIMIT = 8192
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic hit
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] nodes;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            nodes <= '0;
        end else if (inc && !hit) begin
            nodes <= nodes + CNT_W'(1);
        end
    end

    assign hit = (nodes >= CNT_W'(LIMIT));
endmodule

// File: rtl/chain_walker.sv
module chain_walker
    import chain_walk_pkg::*;
#(
    parameter int MEM_AW     = 21,
    parameter int LOOP_LIMIT = 8192,
    parameter int COST_W     = 32,
    parameter int OVERHEAD   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [31:0]       start_addr,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [MEM_AW-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [WORD_W-1:0] mem_rsp_data,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [WORD_W-1:0] cmd_data,
    output logic              busy,
    output logic              done,
    output logic              loop_hit,
    output logic [LINK_W-1:0] progress_addr,
    output logic [COST_W-1:0] cycle_cost
);
    localparam logic [MEM_AW-1:0] WORD_STEP = MEM_AW'(4);

    walk_state_t       st, nxt;
    logic [LINK_W-1:0] cur_addr;
    logic [LINK_W-1:0] next_addr;
    logic [MEM_AW-1:0] rd_addr;
    logic [LEN_W-1:0]  remain;
    logic [WORD_W-1:0] hold_word;
    logic [LEN_W-1:0]  hdr_len;
    logic [LINK_W-1:0] hdr_link;
    logic              guard_hit;
    logic              take_start;
    logic              hdr_take;
    logic [7:0]        unused_start_hi;

    assign unused_start_hi = start_addr[31:24];
    assign take_start = start && (st == ST_IDLE || st == ST_DONE);
    assign hdr_take   = (st == ST_HDR_WAIT) && mem_rsp_valid;

    chain_hdr_split u_split (
        .hdr_word (mem_rsp_data),
        .hdr_len  (hdr_len),
        .hdr_link (hdr_link)
    );

    chain_cost_acc #(.COST_W(COST_W), .OVERHEAD(OVERHEAD)) u_cost (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (take_start),
        .add_en  (hdr_take),
        .add_len (hdr_len),
        .total   (cycle_cost)
    );

    chain_loop_guard #(.LIMIT(LOOP_LIMIT)) u_guard (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (take_start),
        .inc   (hdr_take),
        .hit   (guard_hit)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // next-state decision
    always_comb begin
        nxt = st;
        unique case (st)
            ST_IDLE, ST_DONE: if (start) nxt = ST_CHECK;
            ST_CHECK:    nxt = cur_addr[STOP_BIT] ? ST_DONE : ST_HDR_REQ;
            ST_HDR_REQ:  if (mem_req_ready) nxt = ST_HDR_WAIT;
            ST_HDR_WAIT: if (mem_rsp_valid) nxt = (hdr_len == '0) ? ST_NEXT : ST_PAY_REQ;
            ST_PAY_REQ:  if (mem_req_ready) nxt = ST_PAY_WAIT;
            ST_PAY_WAIT: if (mem_rsp_valid) nxt = ST_PAY_SEND;
            ST_PAY_SEND: if (cmd_ready) nxt = (remain == LEN_W'(1)) ? ST_NEXT : ST_PAY_REQ;
            ST_NEXT:     nxt = (guard_hit && !next_addr[STOP_BIT]) ? ST_DONE : ST_CHECK;
            default:     nxt = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        mem_req_valid = (st == ST_HDR_REQ) || (st == ST_PAY_REQ);
        cmd_valid     = (st == ST_PAY_SEND);
        done          = (st == ST_DONE);
        busy          = (st != ST_IDLE) && (st != ST_DONE);
        mem_req_addr  = rd_addr;
        cmd_data      = hold_word;
    end

    // walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr      <= '0;
            next_addr     <= '0;
            rd_addr       <= '0;
            remain        <= '0;
            hold_word     <= '0;
            loop_hit      <= 1'b0;
            progress_addr <= '0;
        end else begin
            if (take_start) begin
                cur_addr <= start_addr[LINK_W-1:0];
                loop_hit <= 1'b0;
            end
            if (st == ST_CHECK) begin
                rd_addr <= {cur_addr[MEM_AW-1:2], 2'b00};
                if (cur_addr[STOP_BIT]) progress_addr <= cur_addr;
            end
            if (hdr_take) begin
                next_addr <= hdr_link;
                remain    <= hdr_len;
                rd_addr   <= rd_addr + WORD_STEP;
            end
            if (st == ST_PAY_WAIT && mem_rsp_valid) begin
                hold_word <= mem_rsp_data;
            end
            if (st == ST_PAY_SEND && cmd_ready) begin
                remain  <= remain - LEN_W'(1);
                rd_addr <= rd_addr + WORD_STEP;
            end
            if (st == ST_NEXT) begin
                cur_addr <= next_addr;
                if (guard_hit && !next_addr[STOP_BIT]) begin
                    loop_hit      <= 1'b1;
                    progress_addr <= next_addr;
                end
            end
        end
    end
endmodule

// File: rtl/chain_walker_chk.sv
module chain_walker_chk #(
    parameter int MEM_AW = 21
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              loop_hit,
    input logic [23:0]       progress_addr,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic [31:0]       cmd_data,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [MEM_AW-1:0] mem_req_addr
);
    assert_cmd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data));

    assert_no_read_while_waiting_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !mem_req_valid);

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    assert_req_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[1:0] == 2'b00);

    assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));

    assert_stop_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done && !loop_hit |-> progress_addr[23]);

    assert_loop_ends_walk_R9: assert property (@(posedge clk) disable iff (!rst_n)
        loop_hit |-> !busy && !cmd_valid);
endmodule

bind chain_walker chain_walker_chk #(.MEM_AW(MEM_AW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .done          (done),
    .loop_hit      (loop_hit),
    .progress_addr (progress_addr),
    .cmd_valid     (cmd_valid),
    .cmd_ready     (cmd_ready),
    .cmd_data      (cmd_data),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr)
);

// File: tb/chain_walker_bench.sv
`timescale 1ns/1ps
module chain_walker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] start_addr = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b1;
    logic [20:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        cmd_valid;
    logic        cmd_ready = 1'b1;
    logic [31:0] cmd_data;
    logic        busy, done, loop_hit;
    logic [23:0] progress_addr;
    logic [31:0] cycle_cost;

    int checks = 0;
    int errors = 0;
    int reads  = 0;
    int exp_cost;
    bit stall_mode = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    logic [31:0] mem [0:4095];
    logic [31:0] exp_q [$];

    always #2.5 clk = ~clk;

    chain_walker u_chain_walker (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_data(cmd_data), .busy(busy), .done(done), .loop_hit(loop_hit),
        .progress_addr(progress_addr), .cycle_cost(cycle_cost)
    );

    // memory model: one-cycle read latency
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rsp_valid <= 1'b0;
            mem_rsp_data  <= '0;
        end else if (mem_req_valid && mem_req_ready) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= mem[mem_req_addr[13:2]];
            reads         <= reads + 1;
        end else begin
            mem_rsp_valid <= 1'b0;
        end
    end

    // ready drivers, changed just after each edge
    initial forever begin
        @(posedge clk);
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        cmd_ready     = stall_mode ? lfsr[0] : 1'b1;
        mem_req_ready = stall_mode ? lfsr[5] : 1'b1;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // scoreboard monitor
    bit          prev_hold = 1'b0;
    logic [31:0] prev_data = '0;
    initial forever begin
        @(negedge clk);
        if (rst_n) begin
            if (prev_hold) chk(cmd_valid && cmd_data == prev_data, "R8 hold", cmd_data, prev_data);
            if (cmd_valid && cmd_ready) begin
                if (exp_q.size() == 0) chk(1'b0, "R5 unexpected word", cmd_data, 32'h0);
                else begin
                    logic [31:0] e;
                    e = exp_q.pop_front();
                    chk(cmd_data == e, "R5 payload order", cmd_data, e);
                end
            end
            prev_hold = cmd_valid && !cmd_ready;
            prev_data = cmd_data;
        end
    end

    // driver: place a packet and queue its expected words (R3, R4)
    task automatic put_node(input logic [23:0] at, input int len, input logic [23:0] link, input logic [31:0] tag);
        logic [20:0] base;
        base = {at[20:2], 2'b00};
        mem[base[13:2]] = {len[7:0], link};
        for (int k = 1; k <= len; k++) begin
            logic [20:0] a;
            a = base + 21'(4 * k);
            mem[a[13:2]] = tag + 32'(k);
            exp_q.push_back(tag + 32'(k));
        end
        exp_cost += 5 + len;
    endtask

    task automatic run(input logic [31:0] sa, input logic [23:0] exp_prog, input bit exp_loop,
                       input int exp_reads, input string tag);
        int r0, wd;
        r0 = reads;
        @(posedge clk); #1;
        start = 1'b1; start_addr = sa;
        @(posedge clk); #1;
        start = 1'b0;
        wd = 0;
        do begin
            @(negedge clk);
            wd++;
        end while (!done && wd < 60000);
        chk(wd < 60000, {tag, " watchdog"}, 32'(wd), 32'd60000);
        @(negedge clk);
        chk(done && !busy, {tag, " R6 done"}, {30'd0, done, busy}, 32'h2);
        chk(exp_q.size() == 0, {tag, " R5 all words"}, 32'(exp_q.size()), 32'd0);
        chk(cycle_cost == 32'(exp_cost), {tag, " R7 cost"}, cycle_cost, 32'(exp_cost));
        chk(progress_addr == exp_prog, {tag, " R6 progress"}, {8'd0, progress_addr}, {8'd0, exp_prog});
        chk(loop_hit == exp_loop, {tag, " R9 loop flag"}, {31'd0, loop_hit}, {31'd0, exp_loop});
        chk(reads - r0 == exp_reads, {tag, " R4 read count"}, 32'(reads - r0), 32'(exp_reads));
        exp_q.delete();
        exp_cost = 0;
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = '0;
        exp_cost = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !loop_hit && !cmd_valid && !mem_req_valid, "R1 flags",
            {27'd0, busy, done, loop_hit, cmd_valid, mem_req_valid}, 32'd0);
        chk(cycle_cost == 0 && progress_addr == 0, "R1 values", cycle_cost, 32'd0);

        // R2: stopped start, upper byte junk
        run(32'hAB80_0010, 24'h800010, 1'b0, 0, "R2 stopped start");

        // R3/R5: lengths 2, 0, 3; upper start byte ignored
        put_node(24'h000100, 2, 24'h000200, 32'h1000_0000);
        put_node(24'h000200, 0, 24'h000040, 32'h2000_0000);
        put_node(24'h000040, 3, 24'hFFFFFF, 32'h3000_0000);
        run(32'h5A00_0100, 24'hFFFFFF, 1'b0, 8, "R3 mixed chain");

        // R4: bits 22:21 and 1:0 of a link ignored
        put_node(24'h000600, 1, 24'h600301, 32'h4000_0000);
        put_node(24'h600301, 1, 24'h800000, 32'h5000_0000);
        run(32'h0000_0600, 24'h800000, 1'b0, 4, "R4 masked link");

        // R4: payload wraps at the top of the 21-bit space
        put_node(24'h1FFFFC, 2, 24'h800001, 32'h6000_0000);
        run(32'h001F_FFFC, 24'h800001, 1'b0, 3, "R4 wrap");

        // R9: self-linked empty packet trips the guard at 8192 nodes
        mem[12'h140] = {8'd0, 24'h000500};
        exp_cost = 5 * 8192;
        run(32'h0000_0500, 24'h000500, 1'b1, 8192, "R9 loop guard");

        // R8/R10 under random stalls; R9 flag cleared by new start
        stall_mode = 1'b1;
        put_node(24'h000800, 4, 24'h000900, 32'h7000_0000);
        put_node(24'h000900, 5, 24'h880000, 32'h8000_0000);
        run(32'h0000_0800, 24'h880000, 1'b0, 11, "R8 stalls");
        stall_mode = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule